// File: doc/BRIEF.md
# Mixed-Precision 4x4 Tile Multiply-Accumulate Unit

This block computes D = A×B + C on square tiles of DIM×DIM elements. The default is 4×4. A and B hold 16-bit floating-point operands. The format is chosen per run: IEEE half precision (FP16) or brain-float (BF16). The accumulator tile C, and the result D that replaces it in place, are IEEE single precision (FP32). Software first streams the three tiles into local registers through a load port. A single start pulse then runs the whole tile. When the run completes, the result elements are read back by index.

Every 16-bit operand is widened exactly to FP32 before use. Each product is formed and rounded in FP32. Each product is then added into its accumulator element with a round-to-nearest-even FP32 add. The unit issues one product per clock. It walks the output rows outermost, then the output columns, then the reduction index k innermost. A 4×4 tile therefore takes 64 busy cycles and is followed by a one-cycle done pulse.

The load port is a valid/ready stream. A beat transfers on a clock edge where both `ld_valid` and `ld_ready` are high. `ld_ready` is low for the whole of a run, so a producer holding `ld_valid` simply waits, and nothing is written. The read side is combinational and is marked valid whenever no run is in progress. Start, mode, busy and done are plain level or pulse pins.

Top module: `tmac_tile`

## Requirements
- R1: A load beat writes `ld_data[15:0]` into A when `ld_sel`=0. It writes `ld_data[15:0]` into B when `ld_sel`=1, and all 32 bits of `ld_data` into the accumulator tile when `ld_sel`=2. `ld_sel`=3 writes nothing. Element index = row*DIM + column.
- R2: `ld_ready` is low while busy. A beat offered while busy is not taken and leaves every tile unchanged.
- R3: A start pulse seen while idle raises `busy` on the next cycle. `busy` then stays high for exactly DIM³ cycles. `done` is high for exactly one cycle, the first cycle after busy falls. `rd_valid` equals not-busy.
- R4: After a run, element (i,j) holds C(i,j) + A(i,0)B(0,j) + … + A(i,DIM-1)B(DIM-1,j). The terms are added in increasing k, and every product and every add is rounded to nearest, ties to even, in FP32.
- R5: With `fmt_bf16`=0, operands are FP16: 1 sign bit, 5 exponent bits with bias 15, 10 fraction bits. They widen to FP32 by rebiasing the exponent to 127. The mode is captured at start; changing it mid-run has no effect.
- R6: With `fmt_bf16`=1, operands are BF16: 1 sign bit, 8 exponent bits with bias 127, 7 fraction bits. They widen by appending 16 zero bits.
- R7: Any input with a zero exponent field (A, B or C) is treated as a zero of its own sign. A product or sum whose rounded exponent falls below the normal range becomes a zero of its sign.
- R8: Any NaN input, infinity×zero, and the sum of opposite infinities all yield the quiet NaN 0x7FC00000.
- R9: A product or accumulate whose rounded exponent exceeds the FP32 range yields infinity of the result's sign (0x7F800000 or 0xFF800000).
- R10: A start pulse that arrives while busy is ignored. The run length and the result are those of the run already in progress.
- R11: Synchronous reset clears `busy` and `done` and stops any run. It leaves the A, B and accumulator tile contents as they were.
- R12: An exact-zero sum of two nonzero values is +0. The sum of two zeros is -0 only when both are -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_bf16 | input | 1 | Operand format, captured at start: 0 = FP16, 1 = BF16 |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat accepted this cycle (idle) |
| ld_sel | input | 2 | Target tile: 0 = A, 1 = B, 2 = accumulator, 3 = none |
| ld_idx | input | 4 | Element index, row*DIM + column |
| ld_data | input | 32 | Operand in low 16 bits, or FP32 accumulator value |
| start | input | 1 | Start a tile run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result tile is complete |
| rd_idx | input | 4 | Result element index, row*DIM + column |
| rd_valid | output | 1 | Read data meaningful (idle) |
| rd_data | output | 32 | FP32 result element at rd_idx |

## Verification
The bench sweeps many random tiles in each operand format and compares every element against an arithmetic model. The model uses exact real products and sums, rounded once per step. A wrong exponent rebias, a dropped ties-to-even case or a misaligned small addend shows up as off-by-ulp or wildly scaled elements.

Hand-built tiles place NaN, infinity times zero, a product overflow, an accumulate overflow, subnormal operands and signed zeros at known positions. A unit that let a subnormal through, lost the sign of a zero, or cancelled to -0 would return a visibly wrong pattern at those positions.

Runs are also disturbed mid-way by a stray start pulse, a mode flip and a load attempt. A unit that restarted, switched format or accepted the write would change the result or the run length. Reset is exercised after a run to show that the tile survives it.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_ACC  = 2'd2;

  localparam logic [31:0] F32_QNAN = 32'h7FC0_0000;
  localparam logic [7:0]  F32_EMAX = 8'hFF;
endpackage

// File: rtl/tmac_widen.sv
// Exact widening of a 16-bit float (FP16 or BF16) to FP32, with
// zero-exponent inputs flushed to signed zero and NaN made canonical.
module tmac_widen
  import tmac_pkg::*;
(
  input  logic        bf16,
  input  logic [15:0] h,
  output logic [31:0] w
);
  logic [4:0] e5;
  logic [7:0] e8;

  always_comb begin
    e5 = h[14:10];
    e8 = h[14:7];
    if (bf16) begin
      if (e8 == 8'd0)                          w = {h[15], 31'd0};
      else if (e8 == 8'hFF && h[6:0] != 7'd0)  w = F32_QNAN;
      else                                     w = {h, 16'd0};
    end else begin
      if (e5 == 5'd0)                          w = {h[15], 31'd0};
      else if (e5 == 5'h1F)                    w = (h[9:0] != 10'd0) ? F32_QNAN
                                                 : {h[15], F32_EMAX, 23'd0};
      else                                     w = {h[15], {3'd0, e5} + 8'd112, h[9:0], 13'd0};
    end
  end
endmodule

// File: rtl/tmac_fmul.sv
// FP32 multiply, round to nearest even, subnormal flush, overflow to inf.
module tmac_fmul
  import tmac_pkg::*;
(
  input  logic [31:0] x,
  input  logic [31:0] y,
  output logic [31:0] p
);
  logic               sgn, xz, yz, xinf, yinf, xnan, ynan;
  logic [47:0]        prod;
  logic [23:0]        keep;
  logic               grd, stk, rnd;
  logic [24:0]        m25;
  logic signed [9:0]  e_r;

  always_comb begin
    sgn  = x[31] ^ y[31];
    xz   = (x[30:23] == 8'd0);
    yz   = (y[30:23] == 8'd0);
    xinf = (x[30:23] == F32_EMAX) && (x[22:0] == 23'd0);
    yinf = (y[30:23] == F32_EMAX) && (y[22:0] == 23'd0);
    xnan = (x[30:23] == F32_EMAX) && (x[22:0] != 23'd0);
    ynan = (y[30:23] == F32_EMAX) && (y[22:0] != 23'd0);

    prod = {1'b1, x[22:0]} * {1'b1, y[22:0]};
    e_r  = $signed({2'b00, x[30:23]}) + $signed({2'b00, y[30:23]}) - 10'sd127;
    if (prod[47]) begin
      keep = prod[47:24];
      grd  = prod[23];
      stk  = |prod[22:0];
      e_r  = e_r + 10'sd1;
    end else begin
      keep = prod[46:23];
      grd  = prod[22];
      stk  = |prod[21:0];
    end
    rnd = grd & (stk | keep[0]);
    m25 = {1'b0, keep} + {24'd0, rnd};
    if (m25[24]) e_r = e_r + 10'sd1;

    if (xnan || ynan)                     p = F32_QNAN;
    else if ((xinf && yz) || (yinf && xz)) p = F32_QNAN;
    else if (xinf || yinf)                 p = {sgn, F32_EMAX, 23'd0};
    else if (xz || yz)                     p = {sgn, 31'd0};
    else if (e_r >= 10'sd255)              p = {sgn, F32_EMAX, 23'd0};
    else if (e_r <= 10'sd0)                p = {sgn, 31'd0};
    else                                   p = {sgn, e_r[7:0], m25[24] ? m25[23:1] : m25[22:0]};
  end
endmodule

// File: rtl/tmac_fadd.sv
// FP32 add, round to nearest even, subnormal flush, overflow to inf.
module tmac_fadd
  import tmac_pkg::*;
(
  input  logic [31:0] x,
  input  logic [31:0] y,
  output logic [31:0] s
);
  logic [31:0]        big, lit;
  logic               xz, yz, xinf, yinf, xnan, ynan;
  logic [7:0]         diff;
  logic [27:0]        a_al, b_full, b_al, raw;
  logic [26:0]        norm;
  logic [4:0]         lz;
  logic               found, rnd;
  logic [24:0]        m25;
  logic signed [9:0]  e_r;

  always_comb begin
    xz   = (x[30:23] == 8'd0);
    yz   = (y[30:23] == 8'd0);
    xinf = (x[30:23] == F32_EMAX) && (x[22:0] == 23'd0);
    yinf = (y[30:23] == F32_EMAX) && (y[22:0] == 23'd0);
    xnan = (x[30:23] == F32_EMAX) && (x[22:0] != 23'd0);
    ynan = (y[30:23] == F32_EMAX) && (y[22:0] != 23'd0);

    // larger magnitude first
    if (y[30:0] > x[30:0]) begin big = y; lit = x; end
    else                   begin big = x; lit = y; end

    diff   = big[30:23] - lit[30:23];
    a_al   = {1'b0, 1'b1, big[22:0], 3'd0};
    b_full = {1'b0, 1'b1, lit[22:0], 3'd0};
    if (diff > 8'd27) b_al = 28'd1;
    else              b_al = (b_full >> diff) |
                             {27'd0, |(b_full & ((28'd1 << diff) - 28'd1))};

    raw = (big[31] == lit[31]) ? a_al + b_al : a_al - b_al;

    lz    = 5'd0;
    found = 1'b0;
    for (int p = 26; p >= 0; p--) begin
      if (!found && raw[p]) begin
        lz    = 5'(26 - p);
        found = 1'b1;
      end
    end

    if (raw[27]) begin
      norm = {raw[27:2], raw[1] | raw[0]};
      e_r  = $signed({2'b00, big[30:23]}) + 10'sd1;
    end else begin
      norm = raw[26:0] << lz;
      e_r  = $signed({2'b00, big[30:23]}) - $signed({5'd0, lz});
    end

    rnd = norm[2] & (norm[1] | norm[0] | norm[3]);
    m25 = {1'b0, norm[26:3]} + {24'd0, rnd};
    if (m25[24]) e_r = e_r + 10'sd1;

    if (xnan || ynan)                              s = F32_QNAN;
    else if (xinf && yinf && (x[31] != y[31]))     s = F32_QNAN;
    else if (xinf)                                 s = x;
    else if (yinf)                                 s = y;
    else if (xz && yz)                             s = {x[31] & y[31], 31'd0};
    else if (xz)                                   s = y;
    else if (yz)                                   s = x;
    else if (raw == 28'd0)                         s = 32'd0;
    else if (e_r >= 10'sd255)                      s = {big[31], F32_EMAX, 23'd0};
    else if (e_r <= 10'sd0)                        s = {big[31], 31'd0};
    else                                           s = {big[31], e_r[7:0],
                                                        m25[24] ? m25[23:1] : m25[22:0]};
  end
endmodule

// File: rtl/tmac_tile.sv
// Sequential DIM x DIM tile multiply-accumulate: acc <- A x B + acc.
// DIM must be a power of two.
module tmac_tile
  import tmac_pkg::*;
#(
  parameter int DIM  = 4,
  localparam int KW   = $clog2(DIM),
  localparam int IDXW = 2 * KW,
  localparam int NEL  = DIM * DIM,
  localparam int CW   = 3 * KW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fmt_bf16,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [1:0]      ld_sel,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [31:0]     ld_data,
  input  logic            start,
  output logic            busy,
  output logic            done,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_valid,
  output logic [31:0]     rd_data
);
  localparam logic [CW-1:0] LAST_STEP = '1;

  logic [15:0]     a_q   [NEL];
  logic [15:0]     b_q   [NEL];
  logic [31:0]     acc_q [NEL];

  logic            busy_q, done_q, mode_q;
  logic [CW-1:0]   step_q;
  logic            ld_fire;

  logic [KW-1:0]   row, col, kk;
  logic [IDXW-1:0] a_ix, b_ix, d_ix;
  logic [31:0]     wa, wb, prod, sum;

  assign ld_ready = !busy_q;
  assign ld_fire  = ld_valid && ld_ready;

  // step counter: row outermost, then column, then k
  assign row  = step_q[CW-1 -: KW];
  assign col  = step_q[2*KW-1 -: KW];
  assign kk   = step_q[KW-1:0];
  assign a_ix = {row, kk};
  assign b_ix = {kk, col};
  assign d_ix = {row, col};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        step_q <= '0;
        mode_q <= fmt_bf16;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  tmac_widen u_wid_a (.bf16(mode_q), .h(a_q[a_ix]), .w(wa));
  tmac_widen u_wid_b (.bf16(mode_q), .h(b_q[b_ix]), .w(wb));
  tmac_fmul  u_mul   (.x(wa), .y(wb), .p(prod));
  tmac_fadd  u_add   (.x(acc_q[d_ix]), .y(prod), .s(sum));

  // per-element storage; no reset so tiles survive rst
  for (genvar e = 0; e < NEL; e++) begin : g_elem
    always_ff @(posedge clk) begin
      if (ld_fire && ld_sel == SEL_A && ld_idx == IDXW'(e))
        a_q[e] <= ld_data[15:0];
      if (ld_fire && ld_sel == SEL_B && ld_idx == IDXW'(e))
        b_q[e] <= ld_data[15:0];
      if (ld_fire && ld_sel == SEL_ACC && ld_idx == IDXW'(e))
        acc_q[e] <= ld_data;
      else if (busy_q && !rst && d_ix == IDXW'(e))
        acc_q[e] <= sum;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_valid = !busy_q;
  assign rd_data  = acc_q[rd_idx];
endmodule

// File: rtl/tmac_chk.sv
module tmac_chk #(
  parameter int STEPS = 64
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic ld_ready,
  input logic rd_valid
);
  logic [$clog2(STEPS+1):0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R3
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && rd_valid));

  // R2
  ld_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld_ready);

  // R10
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (run_len == STEPS && done));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done));
endmodule

bind tmac_tile tmac_chk #(.STEPS(DIM*DIM*DIM)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ld_ready(ld_ready), .rd_valid(rd_valid)
);

// File: tb/tmac_tile_tb_top.sv
`timescale 1ns/1ps
module tmac_tile_tb_top;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_bf16 = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_sel = 2'd0;
  logic [3:0]  ld_idx = 4'd0;
  logic [31:0] ld_data = 32'd0;
  logic        start = 1'b0;
  logic        busy, done, rd_valid;
  logic [3:0]  rd_idx = 4'd0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_errs   = 0;

  logic [15:0] ta [16];
  logic [15:0] tb [16];
  logic [31:0] tc [16];
  logic [31:0] ed [16];

  always #10 clk = ~clk;

  tmac_tile dut_i (
    .clk(clk), .rst(rst), .fmt_bf16(fmt_bf16),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
    .busy(busy), .done(done), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- arithmetic reference ----------------
  function automatic bit is_nan(logic [31:0] w);
    return w[30:23] == 8'hFF && w[22:0] != 0;
  endfunction
  function automatic bit is_inf(logic [31:0] w);
    return w[30:23] == 8'hFF && w[22:0] == 0;
  endfunction
  function automatic bit is_zero(logic [31:0] w);
    return w[30:23] == 8'd0;
  endfunction

  function automatic real f32_to_real(logic [31:0] w);
    real v;
    v = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** real'(int'(w[30:23]) - 127));
    return w[31] ? -v : v;
  endfunction

  function automatic logic [31:0] real_to_f32(real v);
    logic [63:0] d;
    int e;
    logic [23:0] m;
    logic g, st;
    d = $realtobits(v);
    if (d[62:52] == 0) return {d[63], 31'd0};
    e  = int'(d[62:52]) - 1023 + 127;
    m  = {1'b1, d[51:29]};
    g  = d[28];
    st = |d[27:0];
    if (g && (st || m[0])) begin
      m = m + 1;
      if (m == 0) begin m = 24'h800000; e++; end
    end
    if (e >= 255) return {d[63], 8'hFF, 23'd0};
    if (e <= 0)   return {d[63], 31'd0};
    return {d[63], e[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] widen_ref(bit bf, logic [15:0] h);
    int e;
    real v;
    if (bf) begin
      e = int'(h[14:7]);
      if (e == 0) return {h[15], 31'd0};
      if (e == 255) return (h[6:0] != 0) ? QNAN : {h[15], 8'hFF, 23'd0};
      v = (1.0 + real'(h[6:0]) / 128.0) * (2.0 ** real'(e - 127));
    end else begin
      e = int'(h[14:10]);
      if (e == 0) return {h[15], 31'd0};
      if (e == 31) return (h[9:0] != 0) ? QNAN : {h[15], 8'hFF, 23'd0};
      v = (1.0 + real'(h[9:0]) / 1024.0) * (2.0 ** real'(e - 15));
    end
    return real_to_f32(h[15] ? -v : v);
  endfunction

  function automatic logic [31:0] mul_ref(logic [31:0] x, logic [31:0] y);
    logic s;
    s = x[31] ^ y[31];
    if (is_nan(x) || is_nan(y)) return QNAN;
    if ((is_inf(x) && is_zero(y)) || (is_inf(y) && is_zero(x))) return QNAN;
    if (is_inf(x) || is_inf(y)) return {s, 8'hFF, 23'd0};
    if (is_zero(x) || is_zero(y)) return {s, 31'd0};
    return real_to_f32(f32_to_real(x) * f32_to_real(y));
  endfunction

  function automatic logic [31:0] add_ref(logic [31:0] x, logic [31:0] y);
    real r;
    if (is_nan(x) || is_nan(y)) return QNAN;
    if (is_inf(x) && is_inf(y)) return (x[31] != y[31]) ? QNAN : x;
    if (is_inf(x)) return x;
    if (is_inf(y)) return y;
    if (is_zero(x) && is_zero(y)) return {x[31] & y[31], 31'd0};
    if (is_zero(x)) return y;
    if (is_zero(y)) return x;
    r = f32_to_real(x) + f32_to_real(y);
    if (r == 0.0) return 32'd0;
    return real_to_f32(r);
  endfunction

  task automatic model(input bit bf);
    logic [31:0] acc;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        acc = tc[i*4+j];
        for (int k = 0; k < 4; k++)
          acc = add_ref(acc, mul_ref(widen_ref(bf, ta[i*4+k]), widen_ref(bf, tb[k*4+j])));
        ed[i*4+j] = acc;
      end
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic load_beat(input logic [1:0] sel, input int idx, input logic [31:0] data);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_sel   = sel;
    ld_idx   = 4'(idx);
    ld_data  = data;
  endtask

  task automatic load_all();
    for (int e = 0; e < 16; e++) begin
      load_beat(2'd0, e, {16'hA5A5, ta[e]});
      load_beat(2'd1, e, {16'h5A5A, tb[e]});
      load_beat(2'd2, e, tc[e]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_tile(input bit bf, input bit disturb);
    int n;
    @(negedge clk);
    fmt_bf16 = bf;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (disturb && n == 10) begin
        start    = 1'b1;
        fmt_bf16 = ~bf;
        ld_valid = 1'b1;
        ld_sel   = 2'd2;
        ld_idx   = 4'd0;
        ld_data  = 32'hDEAD_BEEF;
        chk(ld_ready == 1'b0, "R2 ld_ready while busy", 32'(ld_ready), 32'd0);
      end
      if (disturb && n == 11) begin
        start    = 1'b0;
        ld_valid = 1'b0;
      end
      @(negedge clk);
    end
    fmt_bf16 = bf;
    // R3 / R10: run length is DIM^3 even with a stray start
    chk(n == 64, disturb ? "R10 run length" : "R3 run length", 32'(n), 32'd64);
    chk(done == 1'b1, "R3 done after run", 32'(done), 32'd1);
    chk(rd_valid == 1'b1, "R3 rd_valid idle", 32'(rd_valid), 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic read_cmp(input string req);
    for (int e = 0; e < 16; e++) begin
      rd_idx = 4'(e);
      #2;
      chk(rd_data === ed[e], req, rd_data, ed[e]);
    end
  endtask

  function automatic logic [15:0] rand_op(bit bf);
    if (bf) return {1'($urandom), 8'(124 + $urandom % 7), 7'($urandom)};
    return {1'($urandom), 5'(12 + $urandom % 7), 10'($urandom)};
  endfunction

  task automatic rand_tiles(input bit bf);
    for (int e = 0; e < 16; e++) begin
      ta[e] = rand_op(bf);
      tb[e] = rand_op(bf);
      tc[e] = {1'($urandom), 8'(124 + $urandom % 9), 23'($urandom)};
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy after reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R11 done after reset", 32'(done), 32'd0);
    chk(ld_ready == 1'b1, "R2 ld_ready idle", 32'(ld_ready), 32'd1);
    chk(rd_valid == 1'b1, "R3 rd_valid idle", 32'(rd_valid), 32'd1);
    rst = 1'b0;

    // R4 / R5: random FP16 tiles
    for (int t = 0; t < 12; t++) begin
      rand_tiles(1'b0);
      model(1'b0);
      load_all();
      run_tile(1'b0, t == 3);
      read_cmp(t == 3 ? "R5 fp16 mode latched" : "R4 R5 fp16 tile");
    end

    // R4 / R6: random BF16 tiles
    for (int t = 0; t < 12; t++) begin
      rand_tiles(1'b1);
      model(1'b1);
      load_all();
      run_tile(1'b1, t == 5);
      read_cmp(t == 5 ? "R2 R10 bf16 disturbed run" : "R4 R6 bf16 tile");
    end

    // R1: select 3 writes nothing
    load_beat(2'd3, 0, 32'h1234_5678);
    load_beat(2'd3, 5, 32'h0BAD_F00D);
    @(negedge clk);
    ld_valid = 1'b0;
    read_cmp("R1 sel none ignored");

    // R11: reset keeps tile contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R11 flags cleared", {30'd0, busy, done}, 32'd0);
    read_cmp("R11 tile kept over reset");

    // R11: reset in mid-run stops it
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R11 mid-run reset", {30'd0, busy, done}, 32'd0);

    // R7 R8 R9: BF16 special tile
    for (int e = 0; e < 16; e++) begin ta[e] = 16'h0000; tc[e] = 32'd0; end
    ta[0] = 16'h7FC1;                       // NaN
    ta[4] = 16'h7F80;                       // +inf
    ta[8] = 16'h7F00;                       // 2^127
    for (int k = 0; k < 4; k++) ta[12+k] = 16'h3F80;
    tb[0] = 16'h0000; tb[1] = 16'h4000; tb[2] = 16'h3F80; tb[3] = 16'hBF80;
    for (int j = 0; j < 4; j++) begin
      tb[4+j]  = 16'h0001;                  // subnormal
      tb[8+j]  = 16'h3F80;
      tb[12+j] = 16'h3F80;
      tc[4+j]  = 32'h3F80_0000;
      tc[8+j]  = 32'h7F7F_FFFF;
      tc[12+j] = 32'h0000_0001;             // subnormal accumulator
    end
    model(1'b1);
    load_all();
    run_tile(1'b1, 1'b0);
    read_cmp("R7 R8 R9 bf16 special tile");
    rd_idx = 4'd0;  #2; chk(rd_data === QNAN, "R8 NaN operand", rd_data, QNAN);
    rd_idx = 4'd4;  #2; chk(rd_data === QNAN, "R8 inf times zero", rd_data, QNAN);
    rd_idx = 4'd5;  #2; chk(rd_data === PINF, "R9 inf product", rd_data, PINF);
    rd_idx = 4'd9;  #2; chk(rd_data === PINF, "R9 product overflow", rd_data, PINF);
    rd_idx = 4'd10; #2; chk(rd_data === PINF, "R9 accumulate overflow", rd_data, PINF);
    rd_idx = 4'd12; #2; chk(rd_data === 32'h4000_0000, "R7 subnormal flushed", rd_data, 32'h4000_0000);

    // R7 R12: FP16 signed-zero tile
    for (int e = 0; e < 16; e++) begin tb[e] = 16'h3C00; tc[e] = 32'h8000_0000; end
    for (int k = 0; k < 4; k++) begin
      ta[k]    = 16'h8000;
      ta[8+k]  = 16'h0001;
      ta[12+k] = 16'h8001;
    end
    ta[4] = 16'h3C00; ta[5] = 16'hBC00; ta[6] = 16'h0000; ta[7] = 16'h0000;
    model(1'b0);
    load_all();
    run_tile(1'b0, 1'b0);
    read_cmp("R7 R12 fp16 zero tile");
    rd_idx = 4'd0;  #2; chk(rd_data === 32'h8000_0000, "R12 both negative zero", rd_data, 32'h8000_0000);
    rd_idx = 4'd4;  #2; chk(rd_data === 32'h0000_0000, "R12 cancellation positive", rd_data, 32'h0);
    rd_idx = 4'd8;  #2; chk(rd_data === 32'h0000_0000, "R7 fp16 subnormal flushed", rd_data, 32'h0);
    rd_idx = 4'd12; #2; chk(rd_data === 32'h8000_0000, "R7 flushed sign kept", rd_data, 32'h8000_0000);

    finish_run();
  end
endmodule